// File: doc/BRIEF.md
# Half-Rate Comma Phase Aligner

The block takes one received character per clock, together with a flag that marks a framing (comma) character. It hands each character on to an output bus that downstream logic reads at half rate. Every pair of consecutive output slots forms one half-rate period. `phase_out` high marks the true-phase slot and low marks the complement-phase slot. Alignment is on when the framing mode is not off, half-rate output is selected and the framer enable is high. While it is on, the block keeps every comma in the true-phase slot by changing the depth of its data path by one character. It never alters the slot sequence itself.

The path has two states. `ST_SHORT` is one character of latency and `ST_LONG` is two. The transitions are:

- `GROW` (`ST_SHORT` to `ST_LONG`): an incoming active comma would land in the complement slot.
- `SHRINK` (`ST_LONG` to `ST_SHORT`): the same condition arises while the path is two deep.
- `FORCE_SHORT` (any state to `ST_SHORT`): full-rate mode is selected.
- `HOLD`: every other case.

The phase toggle runs freely and flips on every character. The comma flag travels through the same stages as its character.

Top module: `hr_comma_align`

## Requirements
- R1: `phase_out` is 1 in the first cycle after reset and inverts on every following clock; 1 means the true-phase slot.
- R2: The path depth changes only when `frm_mode` is not 2'b00, `half_rate` is 1, `frm_en` is 1 and `comma_in` is 1. A comma under these conditions is called active.
- R3: An active comma always appears at the output in a slot with `phase_out` = 1. The one exception is a `GROW` slot, in which the preceding character is shown again.
- R4: With half-rate selected but alignment off, the depth stays fixed, so a comma can appear in the complement slot.
- R5: `GROW` adds one stage: the slot before the comma repeats the previously output character, and nothing is skipped.
- R6: `SHRINK` removes one stage: the one character just ahead of the comma is skipped, and the stream continues in order from the comma onward.
- R7: `comma_out` is always the flag of the character currently on `chr_out`.
- R8: With `half_rate` = 0 the path is forced to one stage: outputs equal the inputs of the previous clock.
- R9: A synchronous reset (`rst` high) clears the stages, so the outputs read 0 with `comma_out` = 0, sets the depth to `ST_SHORT` and sets the phase to true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| chr_in | input | CHAR_W | Received character |
| comma_in | input | 1 | Framing character flag for `chr_in` |
| frm_mode | input | MODE_W | Framing mode, all zeros = off |
| half_rate | input | 1 | 1 = half-rate output slots, 0 = full rate |
| frm_en | input | 1 | Framer enable |
| chr_out | output | CHAR_W | Aligned character |
| comma_out | output | 1 | Framing flag of `chr_out` |
| phase_out | output | 1 | 1 = true-phase slot, 0 = complement slot |

## Verification
The assertions check four things on every cycle:
- the phase inverts on each clock;
- in full-rate mode the output is the previous input;
- the depth never moves while alignment is off;
- an active comma that leaves one cycle after it entered lands in the true slot.

Three behaviours depend on sequences of characters, so only the bench scenarios can show them: the character repeated on a `GROW`, the character skipped on a `SHRINK`, and commas reaching the complement slot while the framer is disabled. The bench drives an incrementing character stream to expose these.

// File: rtl/hrca_pkg.sv
package hrca_pkg;
    typedef enum logic {
        ST_SHORT = 1'b0,
        ST_LONG  = 1'b1
    } depth_e;
endpackage

// File: rtl/hrca_phase_tog.sv
module hrca_phase_tog (
    input  logic clk,
    input  logic rst,
    output logic phase_true
);
    always_ff @(posedge clk) begin
        if (rst) phase_true <= 1'b1;
        else     phase_true <= ~phase_true;
    end

    // R1
    phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (phase_true != $past(phase_true)));
endmodule

// File: rtl/hrca_delay.sv
module hrca_delay #(
    parameter int ENTRY_W = 11,
    parameter int NSTAGE  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRY_W-1:0] din,
    output logic [ENTRY_W-1:0] tap1,
    output logic [ENTRY_W-1:0] tap2
);
    logic [ENTRY_W-1:0] stg [NSTAGE];

    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign tap1 = stg[0];
    assign tap2 = stg[NSTAGE-1];
endmodule

// File: rtl/hrca_ctrl.sv
module hrca_ctrl
    import hrca_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   half_rate,
    input  logic   align_act,
    input  logic   comma_in,
    input  logic   phase_true,
    output depth_e state
);
    depth_e nxt;
    logic   land_true;
    logic   slip;

    // slot the incoming comma would reach at the current depth
    assign land_true = (state == ST_LONG) ? phase_true : ~phase_true;
    assign slip      = align_act & comma_in & ~land_true;

    always_comb begin
        nxt = state;
        if (!half_rate) begin
            nxt = ST_SHORT;                 // FORCE_SHORT
        end else begin
            unique case (state)
                ST_SHORT: if (slip) nxt = ST_LONG;   // GROW
                ST_LONG:  if (slip) nxt = ST_SHORT;  // SHRINK
                default:  nxt = ST_SHORT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_SHORT;
        else     state <= nxt;
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(half_rate) && !$past(align_act)) |-> (state == $past(state)));
endmodule

// File: rtl/hr_comma_align.sv
module hr_comma_align
    import hrca_pkg::*;
#(
    parameter int CHAR_W = 10,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CHAR_W-1:0] chr_in,
    input  logic              comma_in,
    input  logic [MODE_W-1:0] frm_mode,
    input  logic              half_rate,
    input  logic              frm_en,
    output logic [CHAR_W-1:0] chr_out,
    output logic              comma_out,
    output logic              phase_out
);
    localparam int ENTRY_W = CHAR_W + 1;

    logic               align_act;
    logic               phase_true;
    logic [ENTRY_W-1:0] tap1, tap2;
    depth_e             state;

    assign align_act = (frm_mode != '0) & half_rate & frm_en;

    hrca_phase_tog u_tog (
        .clk        (clk),
        .rst        (rst),
        .phase_true (phase_true)
    );

    hrca_delay #(.ENTRY_W(ENTRY_W), .NSTAGE(2)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .din  ({comma_in, chr_in}),
        .tap1 (tap1),
        .tap2 (tap2)
    );

    hrca_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .half_rate  (half_rate),
        .align_act  (align_act),
        .comma_in   (comma_in),
        .phase_true (phase_true),
        .state      (state)
    );

    always_comb begin
        unique case (state)
            ST_SHORT: {comma_out, chr_out} = tap1;
            ST_LONG:  {comma_out, chr_out} = tap2;
            default:  {comma_out, chr_out} = tap1;
        endcase
    end

    assign phase_out = phase_true;

    // R8
    full_rate_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(half_rate)) |->
        ({comma_out, chr_out} == $past({comma_in, chr_in})));

    // R3
    comma_true_slot_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(align_act && comma_in) && state == ST_SHORT) |-> phase_out);
endmodule

// File: tb/hr_comma_align_test.sv
module hr_comma_align_test;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] chr_in = '0;
    logic         comma_in = 1'b0;
    logic [1:0]   frm_mode = 2'b00;
    logic         half_rate = 1'b0;
    logic         frm_en = 1'b0;
    logic [W-1:0] chr_out;
    logic         comma_out;
    logic         phase_out;

    always #10 clk = ~clk;

    hr_comma_align #(.CHAR_W(W), .MODE_W(2)) uut (
        .clk(clk), .rst(rst), .chr_in(chr_in), .comma_in(comma_in),
        .frm_mode(frm_mode), .half_rate(half_rate), .frm_en(frm_en),
        .chr_out(chr_out), .comma_out(comma_out), .phase_out(phase_out)
    );

    int checks = 0;
    int fails  = 0;
    int grows = 0, shrinks = 0, r4_cmp = 0, r3_hits = 0;
    logic [W+1:0] hist [$];     // {active, comma, char}, newest first
    int           lat = 1;
    bit           ph  = 1'b1;
    logic [W-1:0] cnt = '0;
    logic [W-1:0] prev_chr = '0;
    bit           done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input bit r, input bit c, input logic [1:0] m, input bit h, input bit e);
        bit act, grew, shrank, land;
        int nlat;
        logic [W+1:0] ex;
        rst = r; comma_in = c; frm_mode = m; half_rate = h; frm_en = e; chr_in = cnt;
        act = (m != 2'b00) && h && e;
        @(posedge clk);
        grew = 0; shrank = 0;
        if (r) begin
            hist.delete();
            hist.push_front('0);
            hist.push_front('0);
            lat = 1; ph = 1'b1;
        end else begin
            nlat = lat;
            if (!h) nlat = 1;
            else if (act && c) begin
                land = (lat == 2) ? ph : !ph;
                if (!land) nlat = 3 - lat;
            end
            hist.push_front({act, c, cnt});
            if (hist.size() > 2) void'(hist.pop_back());
            grew = nlat > lat; shrank = nlat < lat;
            lat = nlat; ph = !ph;
        end
        cnt = cnt + 1'b1;
        ex = hist[lat-1];
        @(negedge clk);
        if (r)               chk(chr_out == ex[W-1:0], "R9", chr_out, ex[W-1:0]);
        else if (!h)         chk(chr_out == ex[W-1:0], "R8", chr_out, ex[W-1:0]);
        else if (!act)       chk(chr_out == ex[W-1:0], "R4", chr_out, ex[W-1:0]);
        else                 chk(chr_out == ex[W-1:0], "R2", chr_out, ex[W-1:0]);
        chk(comma_out == ex[W], "R7", comma_out, ex[W]);
        chk(phase_out == ph, "R1", phase_out, ph);
        if (grew) begin
            grows++;
            chk(chr_out == prev_chr, "R5", chr_out, prev_chr);
        end
        if (shrank) begin
            shrinks++;
            chk(chr_out == prev_chr + W'(2), "R6", chr_out, prev_chr + W'(2));
        end
        if (!r && h && ex[W] && ex[W+1] && !grew) begin
            r3_hits++;
            chk(phase_out == 1'b1, "R3", phase_out, 1);
        end
        if (!r && h && ex[W] && !ex[W+1] && !phase_out) r4_cmp++;
        prev_chr = chr_out;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
        end
    end

    initial begin
        // R9 reset state
        tick(1, 0, 2'b00, 0, 0);
        tick(1, 1, 2'b01, 1, 1);
        chk(chr_out == '0 && comma_out == 1'b0, "R9", {comma_out, chr_out}, 0);
        chk(phase_out == 1'b1, "R9", phase_out, 1);
        // active alignment, several comma spacings
        for (int k = 0; k < 60; k++) tick(0, (k % 5) == 2, 2'b01, 1, 1);
        for (int k = 0; k < 60; k++) tick(0, (k % 8) == 3, 2'b10, 1, 1);
        for (int k = 0; k < 40; k++) tick(0, (k % 3) == 0, 2'b11, 1, 1);
        // back-to-back commas
        for (int k = 0; k < 30; k++) tick(0, (k % 10) < 2, 2'b01, 1, 1);
        // framer disabled, then mode off: odd spacings
        for (int k = 0; k < 50; k++) tick(0, (k % 7) == 1, 2'b01, 1, 0);
        for (int k = 0; k < 50; k++) tick(0, (k % 9) == 4, 2'b00, 1, 1);
        // full rate
        for (int k = 0; k < 40; k++) tick(0, (k % 4) == 1, 2'b01, 0, 1);
        // back to half rate
        for (int k = 0; k < 50; k++) tick(0, (k % 6) == 5, 2'b01, 1, 1);
        // mid-run reset and resume
        tick(1, 0, 2'b01, 1, 1);
        chk(chr_out == '0 && phase_out == 1'b1, "R9", {phase_out, chr_out}, 11'h400);
        for (int k = 0; k < 40; k++) tick(0, (k % 11) == 6, 2'b01, 1, 1);
        chk(grows > 0,   "R5", grows, 1);
        chk(shrinks > 0, "R6", shrinks, 1);
        chk(r3_hits > 0, "R3", r3_hits, 1);
        chk(r4_cmp > 0,  "R4", r4_cmp, 1);
        done = 1'b1;
        summary();
    end
endmodule